// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small processor core that runs one instruction at a time and spends several clock cycles on each one. A control state machine walks a fixed list of micro-operations: it fetches, decodes and then executes. Every memory access passes through an 8-bit address latch and a 16-bit data latch. Instructions are 16 bits wide and take one operand. A mode bit says whether the operand is one of eight general registers or a direct location in a 256-word, 16-bit memory. General register 0 serves as the accumulator and holds every result. An ADD updates a zero flag and a carry flag. A LOAD updates the zero flag only.

The memory sits inside the core. While reset is held low, a preload port writes a program and its data into that memory. When reset is released, the core fetches from address 0 and keeps running until it executes a HALT. The accumulator, the program counter, both flags and a halted indication are visible at the ports.

Top module: `acc_core`

## Requirements
- R1: An instruction is one 16-bit word laid out as opcode in bits [15:9], mode in bit [8] and operand in bits [7:0]. The opcodes are 0 = HALT, 1 = ADD, 2 = LOAD and 3 = STORE.
- R2: With mode 1 the operand names a register, and only operand bits [2:0] select it; bits [7:3] have no effect. With mode 0 the operand is a direct memory address.
- R3: Results are written to register 0, which `acc_out` shows.
- R4: While `rst_n` is low, PC, all registers and both flags read 0 and `halted` is 0, and a high `pl_we` writes `pl_data` to memory at `pl_addr`. After reset is released, fetching starts at address 0.
- R5: The PC rises by one on the 4th clock edge of every instruction and changes at no other time. Each instruction takes a fixed number of cycles: 6 for ADD or LOAD with a register operand, 8 for ADD or LOAD from memory, 5 for STORE to a register, 7 for STORE to memory, and 5 for any other opcode.
- R6: ADD sets the accumulator to (accumulator + operand) mod 2^16. The carry flag takes bit 16 of the sum, and the zero flag is set when the 16-bit result is 0. No other instruction changes the carry flag.
- R7: LOAD copies the operand into the accumulator and updates only the zero flag.
- R8: STORE writes the accumulator to the selected register or memory word and leaves both flags unchanged.
- R9: HALT raises `halted` on the 5th edge of the instruction. After that, `halted`, the PC, the accumulator and the flags stay unchanged until reset.
- R10: Opcodes 4 to 127 change nothing except the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; preload window |
| pl_we | input | 1 | Preload write enable (acted on only in reset) |
| pl_addr | input | 8 | Preload word address |
| pl_data | input | 16 | Preload write data |
| acc_out | output | 16 | Register 0 (accumulator) |
| pc_out | output | 8 | Program counter |
| zero_flag | output | 1 | Zero flag |
| carry_flag | output | 1 | Carry flag |
| halted | output | 1 | High once HALT has executed |

## Verification
The bench's reference model counts clock edges from the start of each instruction. It moves its expected PC on the 4th edge, applies the instruction's effect on the last edge of that instruction's cycle count (5, 6, 7 or 8), and raises its halted flag on the 5th edge of a HALT. The model updates at each rising edge and the design's ports are compared with it at the following falling edge, so every result is checked in the exact cycle it becomes due. A stored value is checked by loading it back later in the program. The operand bits that must be ignored are checked through the accumulator value they would otherwise change.

// File: rtl/acc_pkg.sv
package acc_pkg;
   localparam logic [6:0] OP_HALT  = 7'd0;
   localparam logic [6:0] OP_ADD   = 7'd1;
   localparam logic [6:0] OP_LOAD  = 7'd2;
   localparam logic [6:0] OP_STORE = 7'd3;

   typedef enum logic [3:0] {
      S_F0, S_F1, S_F2, S_F3, S_DEC, S_M0, S_M1, S_EX, S_ST, S_SW, S_HALT
   } step_t;

   typedef struct packed {
      logic mar_pc;
      logic mar_ir;
      logic dr_mem;
      logic dr_reg;
      logic dr_acc;
      logic ir_ld;
      logic pc_inc;
      logic add_en;
      logic ld_en;
      logic st_reg;
      logic mem_wr;
   } ctl_t;
endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
   parameter int DW = 16,
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] ram [DEPTH];

   always_ff @(posedge clk) begin
      if (we) ram[addr] <= wdata;
      rdata <= ram[addr];
   end
endmodule

// File: rtl/acc_regfile.sv
module acc_regfile #(
   parameter int DW   = 16,
   parameter int NREG = 8,
   localparam int RSW = $clog2(NREG)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we,
   input  logic [RSW-1:0] waddr,
   input  logic [DW-1:0]  wdata,
   input  logic [RSW-1:0] raddr,
   output logic [DW-1:0]  rdata,
   output logic [DW-1:0]  acc
);
   logic [DW-1:0] r [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)                       r[g] <= '0;
         else if (we && waddr == RSW'(g))  r[g] <= wdata;
      end
   end

   assign rdata = r[raddr];
   assign acc   = r[0];
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
   import acc_pkg::*;
#(
   parameter int OPW = 7
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [OPW-1:0] opcode,
   input  logic           mode,
   output ctl_t           ctl,
   output logic           halted
);
   step_t st, nxt;

   always_ff @(posedge clk) begin
      if (!rst_n) st <= S_F0;
      else        st <= nxt;
   end

   always_comb begin
      nxt = st;
      ctl = '0;
      case (st)
         S_F0:  begin ctl.mar_pc = 1'b1; nxt = S_F1; end
         S_F1:  nxt = S_F2;
         S_F2:  begin ctl.dr_mem = 1'b1; nxt = S_F3; end
         S_F3:  begin ctl.ir_ld = 1'b1; ctl.pc_inc = 1'b1; nxt = S_DEC; end
         S_DEC: begin
            case (opcode)
               OPW'(OP_HALT): nxt = S_HALT;
               OPW'(OP_ADD), OPW'(OP_LOAD): begin
                  if (mode) begin ctl.dr_reg = 1'b1; nxt = S_EX; end
                  else      begin ctl.mar_ir = 1'b1; nxt = S_M0; end
               end
               OPW'(OP_STORE): begin
                  if (mode) begin ctl.st_reg = 1'b1; nxt = S_F0; end
                  else      begin ctl.mar_ir = 1'b1; nxt = S_ST; end
               end
               default: nxt = S_F0;
            endcase
         end
         S_M0:  nxt = S_M1;
         S_M1:  begin ctl.dr_mem = 1'b1; nxt = S_EX; end
         S_EX:  begin
            ctl.add_en = (opcode == OPW'(OP_ADD));
            ctl.ld_en  = (opcode == OPW'(OP_LOAD));
            nxt = S_F0;
         end
         S_ST:  begin ctl.dr_acc = 1'b1; nxt = S_SW; end
         S_SW:  begin ctl.mem_wr = 1'b1; nxt = S_F0; end
         S_HALT: nxt = S_HALT;
         default: nxt = S_F0;
      endcase
   end

   assign halted = (st == S_HALT);
endmodule

// File: rtl/acc_core.sv
module acc_core
   import acc_pkg::*;
#(
   parameter int DW   = 16,
   parameter int AW   = 8,
   parameter int OPW  = 7,
   parameter int NREG = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pl_we,
   input  logic [AW-1:0] pl_addr,
   input  logic [DW-1:0] pl_data,
   output logic [DW-1:0] acc_out,
   output logic [AW-1:0] pc_out,
   output logic          zero_flag,
   output logic          carry_flag,
   output logic          halted
);
   localparam int RSW = $clog2(NREG);
   localparam int MB  = AW;

   if (OPW + 1 + AW != DW) begin : g_bad_fmt
      $error("instruction fields do not fill the word");
   end
   if (RSW > AW) begin : g_bad_sel
      $error("register select wider than operand field");
   end

   logic [AW-1:0] pc_q, mar_q;
   logic [DW-1:0] dr_q, ir_q, mem_q, reg_rd, acc;
   logic          fz_q, fc_q;
   ctl_t          ctl;
   logic [DW:0]   sum;
   logic [OPW-1:0] opcode;
   logic           mode;
   logic [RSW-1:0] sel;

   assign opcode = ir_q[DW-1 -: OPW];
   assign mode   = ir_q[MB];
   assign sel    = ir_q[RSW-1:0];
   assign sum    = {1'b0, acc} + {1'b0, dr_q};

   acc_ctrl #(.OPW(OPW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .mode(mode),
      .ctl(ctl), .halted(halted)
   );

   logic           rf_we;
   logic [RSW-1:0] rf_wa;
   logic [DW-1:0]  rf_wd;

   assign rf_we = ctl.add_en | ctl.ld_en | ctl.st_reg;
   assign rf_wa = ctl.st_reg ? sel : '0;
   assign rf_wd = ctl.add_en ? sum[DW-1:0] : (ctl.ld_en ? dr_q : acc);

   acc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
      .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_wa), .wdata(rf_wd),
      .raddr(sel), .rdata(reg_rd), .acc(acc)
   );

   logic          m_we;
   logic [AW-1:0] m_addr;
   logic [DW-1:0] m_wd;

   assign m_we   = rst_n ? ctl.mem_wr : pl_we;
   assign m_addr = rst_n ? mar_q : pl_addr;
   assign m_wd   = rst_n ? dr_q : pl_data;

   acc_mem #(.DW(DW), .AW(AW)) u_mem (
      .clk(clk), .we(m_we), .addr(m_addr), .wdata(m_wd), .rdata(mem_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q  <= '0;
         mar_q <= '0;
         dr_q  <= '0;
         ir_q  <= '0;
         fz_q  <= 1'b0;
         fc_q  <= 1'b0;
      end else begin
         if (ctl.mar_pc) mar_q <= pc_q;
         if (ctl.mar_ir) mar_q <= ir_q[AW-1:0];
         if (ctl.dr_mem) dr_q <= mem_q;
         if (ctl.dr_reg) dr_q <= reg_rd;
         if (ctl.dr_acc) dr_q <= acc;
         if (ctl.ir_ld)  ir_q <= dr_q;
         if (ctl.pc_inc) pc_q <= pc_q + AW'(1);
         if (ctl.add_en) begin
            fc_q <= sum[DW];
            fz_q <= (sum[DW-1:0] == '0);
         end
         if (ctl.ld_en) fz_q <= (dr_q == '0);
      end
   end

   assign acc_out    = acc;
   assign pc_out     = pc_q;
   assign zero_flag  = fz_q;
   assign carry_flag = fc_q;

   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pc_q) |-> pc_q == $past(pc_q) + AW'(1)); // R5
   AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted && $stable(pc_q) && $stable(acc)); // R9
   AST_CARRY_BY_ADD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fc_q) |-> $past(ctl.add_en)); // R6
   AST_MEM_WR_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.mem_wr |-> (opcode == OPW'(OP_STORE)) && !mode); // R8
   AST_ACC_WRITERS: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(acc) |-> $past(ctl.add_en || ctl.ld_en || (ctl.st_reg && sel == '0))); // R3
endmodule

// File: tb/sim_acc_core.sv
module sim_acc_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pl_we = 1'b0;
   logic [7:0]  pl_addr = '0;
   logic [15:0] pl_data = '0;
   logic [15:0] acc_out;
   logic [7:0]  pc_out;
   logic        zero_flag, carry_flag, halted;

   always #10 clk = ~clk;

   acc_core u0 (
      .clk(clk), .rst_n(rst_n), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
      .acc_out(acc_out), .pc_out(pc_out), .zero_flag(zero_flag),
      .carry_flag(carry_flag), .halted(halted)
   );

   int total = 0;
   int bad = 0;

   // reference model state
   logic [15:0] m_mem [256];
   logic [15:0] m_regs [8];
   logic [7:0]  m_pc;
   logic        m_z, m_c, m_halt;
   logic [15:0] m_ir;
   int          step;
   string       cur_tag = "R10";
   bit          cmp_on = 1'b0;

   function automatic logic [15:0] enc(input int op, input int md, input int opnd);
      return 16'((op << 9) | (md << 8) | (opnd & 255));
   endfunction

   function automatic int dur(input logic [15:0] i);
      case (i[15:9])
         7'd1, 7'd2: return i[8] ? 6 : 8;
         7'd3:       return i[8] ? 5 : 7;
         default:    return 5;
      endcase
   endfunction

   function automatic string tag_of(input logic [15:0] i);
      case (i[15:9])
         7'd0: return "R9";
         7'd1: return "R6";
         7'd2: return "R7";
         7'd3: return "R8";
         default: return "R10";
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         step = 0; m_pc = '0; m_z = 1'b0; m_c = 1'b0; m_halt = 1'b0;
         for (int k = 0; k < 8; k++) m_regs[k] = '0;
      end else if (!m_halt) begin
         logic [15:0] v;
         logic [16:0] s;
         step++;
         if (step == 1) begin m_ir = m_mem[m_pc]; cur_tag = tag_of(m_ir); end
         if (step == 4) m_pc = m_pc + 8'd1;
         if (step == dur(m_ir)) begin
            v = m_ir[8] ? m_regs[m_ir[2:0]] : m_mem[m_ir[7:0]];
            case (m_ir[15:9])
               7'd0: m_halt = 1'b1;
               7'd1: begin
                  s = {1'b0, m_regs[0]} + {1'b0, v};
                  m_regs[0] = s[15:0]; m_c = s[16]; m_z = (s[15:0] == 16'd0);
               end
               7'd2: begin m_regs[0] = v; m_z = (v == 16'd0); end
               7'd3: if (m_ir[8]) m_regs[m_ir[2:0]] = m_regs[0];
                     else m_mem[m_ir[7:0]] = m_regs[0];
               default: ;
            endcase
            step = 0;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         chk(cur_tag, 32'(acc_out), 32'(m_regs[0]));
         chk("R5", 32'(pc_out), 32'(m_pc));
         chk(cur_tag, {30'd0, zero_flag, carry_flag}, {30'd0, m_z, m_c});
         chk("R9", 32'(halted), 32'(m_halt));
      end
   end

   task automatic poke(input int a, input logic [15:0] d);
      @(negedge clk);
      pl_we = 1'b1; pl_addr = 8'(a); pl_data = d;
      m_mem[8'(a)] = d;
   endtask

   task automatic enter_reset;
      @(negedge clk);
      rst_n = 1'b0; cmp_on = 1'b0;
   endtask

   task automatic leave_reset;
      @(negedge clk);
      pl_we = 1'b0;
      @(negedge clk);
      chk("R4", {acc_out, pc_out, zero_flag, carry_flag, halted, 5'd0}, 32'd0);
      rst_n = 1'b1; cmp_on = 1'b1;
   endtask

   task automatic run_to_halt;
      int k;
      for (k = 0; k < 3000 && !halted; k++) @(negedge clk);
      if (!halted) begin
         bad++; total++;
         $display("FAIL R9 watchdog: actual=no halt expected=halt");
      end
      repeat (4) @(negedge clk);
   endtask

   initial begin
      for (int k = 0; k < 256; k++) m_mem[k] = '0;
      enter_reset;
      // data words
      poke(8'h80, 16'hFFFF);
      poke(8'h81, 16'h0001);
      poke(8'h82, 16'h1234);
      // program 1
      poke(0,  enc(2, 0, 8'h82));   // LOAD mem -> 1234
      poke(1,  enc(3, 1, 8'hFA));   // STORE to r2 (bits 7:3 ignored)
      poke(2,  enc(2, 0, 8'h80));   // LOAD FFFF
      poke(3,  enc(1, 0, 8'h81));   // ADD 1 -> 0, carry
      poke(4,  enc(1, 1, 2));       // ADD r2 -> 1234
      poke(5,  enc(3, 0, 8'h90));   // STORE mem 0x90
      poke(6,  enc(2, 0, 8'h81));   // LOAD 1
      poke(7,  enc(85, 1, 3));      // no-op opcode
      poke(8,  enc(2, 0, 8'h90));   // LOAD back stored word
      poke(9,  enc(1, 1, 0));       // ADD r0 -> 2468
      poke(10, enc(1, 0, 8'h80));   // ADD FFFF -> 2467 carry
      poke(11, enc(2, 1, 5));       // LOAD r5 (0), carry kept
      poke(12, enc(0, 0, 0));       // HALT
      leave_reset;
      run_to_halt;
      chk("R1", 32'(pc_out), 32'd13);
      chk("R3", 32'(acc_out), 32'd0);
      chk("R7", {30'd0, zero_flag, carry_flag}, 32'd3);
      chk("R9", 32'(halted), 32'd1);

      // second run: reset clears state, operand high bits ignored
      enter_reset;
      poke(8'h10, 16'h4000);
      poke(0, enc(2, 0, 8'h10));    // LOAD 4000
      poke(1, enc(1, 1, 8'hF8));    // ADD reg sel 0 -> 8000
      poke(2, enc(1, 1, 8'h08));    // ADD reg sel 0 -> 0, carry
      poke(3, enc(0, 0, 0));        // HALT
      leave_reset;
      chk("R4", 32'(pc_out), 32'd0);
      run_to_halt;
      chk("R2", 32'(acc_out), 32'd0);
      chk("R2", {30'd0, zero_flag, carry_flag}, 32'd3);
      chk("R9", 32'(pc_out), 32'd4);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule